// File: doc/BRIEF.md
# Two-Queue Weighted Transmit Scheduler

This block sits in front of an egress port that has two transmit queues, an urgent one and a bulk one. Each queue reports only whether it holds at least one packet. The scheduler picks which queue sends the next whole packet and holds that grant until the port pulses `pkt_done` at the end of the packet. A 3-bit setting chooses the share between the two queues. The lowest setting gives strict priority to the urgent queue. The highest setting makes the two queues alternate.

The block does not handle packet data. The grant is a plain control signal, so no valid/ready handshake is involved. The grant is driven from a register. A new grant can follow the end of the previous packet with no idle cycle between them. The scheduler never idles while a queue holds work. When only one queue is non-empty it is served at once, and this uncontested grant leaves the sharing count unchanged.

Top module: `txq_pair_sched`

## Requirements
- R1: At most one of `grant_hi` and `grant_lo` is high in any cycle. Both are low during reset and in the first cycle after it.
- R2: While a grant is active and `pkt_done` is low, the grant stays unchanged.
- R3: A scheduling decision is taken in every cycle where no grant is active or where `pkt_done` is high. Its result appears on the grant outputs in the next cycle, so one packet can follow another back to back.
- R4: When a decision is taken and both queues are empty, no grant is active in the next cycle.
- R5: When a decision is taken and exactly one queue is non-empty, that queue is granted. The count of consecutive urgent grants is not changed.
- R6: With `ratio_sel` = 0, whenever the urgent queue is non-empty at a decision it is granted. The bulk queue is granted only when the urgent queue is empty.
- R7: With `ratio_sel` = n, where n is 1 to 7, and both queues non-empty at a decision: the bulk queue is granted once the count of consecutive contended urgent grants has reached 8 − n. Otherwise the urgent queue is granted and the count is incremented. A contended bulk grant clears the count. Reset also clears it.
- R8: With `ratio_sel` = 7 and both queues always non-empty, grants alternate between the urgent queue and the bulk queue.
- R9: A `pkt_done` pulse in a cycle with no active grant behaves exactly like an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_nonempty | input | 1 | Urgent queue holds at least one packet |
| lo_nonempty | input | 1 | Bulk queue holds at least one packet |
| pkt_done | input | 1 | Last cycle of the packet now being sent |
| ratio_sel | input | 3 | Share setting: 0 strict, 1 to 7 from 7:1 up to 1:1 |
| grant_hi | output | 1 | Urgent queue owns the port for the current packet |
| grant_lo | output | 1 | Bulk queue owns the port for the current packet |

## Verification
The bench targets the boundary where the count reaches its limit. A design that is off by one here would send one urgent packet too many or too few before each bulk packet, and the 1:1 setting would stop alternating. It also checks uncontested grants. A design that counted those grants would serve the bulk queue early once contention resumes. The bench checks back-to-back handover on `pkt_done` and stray `pkt_done` pulses while idle. A wrong design would leave a dead cycle between packets, or switch queues in the middle of a packet. Strict mode is tested with the bulk queue always non-empty, so any bulk grant that starves the urgent queue shows up.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;
  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_HI   = 2'd1,
    GNT_LO   = 2'd2
  } gnt_e;
endpackage

// File: rtl/txq_weight_map.sv
module txq_weight_map #(
  parameter int RATIO_W = 3,
  localparam int WGT_W = RATIO_W + 1
) (
  input  logic [RATIO_W-1:0] ratio_sel,
  output logic               strict,
  output logic [WGT_W-1:0]   weight
);
  // Setting n>0 allows (2^RATIO_W - n) urgent packets per bulk packet.
  always_comb begin
    strict = (ratio_sel == '0);
    weight = WGT_W'(1 << RATIO_W) - {1'b0, ratio_sel};
  end
endmodule

// File: rtl/txq_pick.sv
module txq_pick
  import txq_sched_pkg::*;
#(
  parameter int RATIO_W = 3,
  localparam int WGT_W = RATIO_W + 1,
  localparam int CNT_W = RATIO_W
) (
  input  logic             hi_req,
  input  logic             lo_req,
  input  logic             strict,
  input  logic [WGT_W-1:0] weight,
  input  logic [CNT_W-1:0] run_cnt,
  output gnt_e             pick,
  output logic [CNT_W-1:0] run_cnt_nxt
);
  logic quota_used;

  always_comb begin
    quota_used  = ({1'b0, run_cnt} >= weight);
    pick        = GNT_NONE;
    run_cnt_nxt = run_cnt;
    if (hi_req && lo_req) begin
      if (strict) begin
        pick = GNT_HI;
      end else if (quota_used) begin
        pick        = GNT_LO;
        run_cnt_nxt = '0;
      end else begin
        pick        = GNT_HI;
        run_cnt_nxt = run_cnt + CNT_W'(1);
      end
    end else if (hi_req) begin
      pick = GNT_HI;
    end else if (lo_req) begin
      pick = GNT_LO;
    end
  end
endmodule

// File: rtl/txq_pair_sched.sv
module txq_pair_sched
  import txq_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hi_nonempty,
  input  logic       lo_nonempty,
  input  logic       pkt_done,
  input  logic [2:0] ratio_sel,
  output logic       grant_hi,
  output logic       grant_lo
);
  localparam int RATIO_W = 3;
  localparam int WGT_W   = RATIO_W + 1;
  localparam int CNT_W   = RATIO_W;

  gnt_e             gnt_q;
  gnt_e             gnt_pick;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nxt;
  logic             strict;
  logic [WGT_W-1:0] weight;
  logic             decide;

  txq_weight_map #(.RATIO_W(RATIO_W)) u_wmap (
    .ratio_sel (ratio_sel),
    .strict    (strict),
    .weight    (weight)
  );

  txq_pick #(.RATIO_W(RATIO_W)) u_pick (
    .hi_req      (hi_nonempty),
    .lo_req      (lo_nonempty),
    .strict      (strict),
    .weight      (weight),
    .run_cnt     (run_q),
    .pick        (gnt_pick),
    .run_cnt_nxt (run_nxt)
  );

  assign decide = (gnt_q == GNT_NONE) || pkt_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= GNT_NONE;
      run_q <= '0;
    end else if (decide) begin
      gnt_q <= gnt_pick;
      run_q <= run_nxt;
    end
  end

  assign grant_hi = (gnt_q == GNT_HI);
  assign grant_lo = (gnt_q == GNT_LO);
endmodule

// File: rtl/txq_pair_sched_chk.sv
module txq_pair_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hi_nonempty,
  input logic       lo_nonempty,
  input logic       pkt_done,
  input logic [2:0] ratio_sel,
  input logic       grant_hi,
  input logic       grant_lo
);
  logic idle;
  logic dec;
  assign idle = !grant_hi && !grant_lo;
  assign dec  = idle || pkt_done;

  p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({grant_hi, grant_lo}) <= 1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !pkt_done) |=> ($stable(grant_hi) && $stable(grant_lo)));

  p_work_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && (hi_nonempty || lo_nonempty)) |=> (grant_hi || grant_lo));

  p_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !hi_nonempty && !lo_nonempty) |=> (!grant_hi && !grant_lo));

  p_only_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && lo_nonempty && !hi_nonempty) |=> grant_lo);

  p_only_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && hi_nonempty && !lo_nonempty) |=> grant_hi);

  p_strict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && hi_nonempty && ratio_sel == 3'd0) |=> grant_hi);
endmodule

bind txq_pair_sched txq_pair_sched_chk u_chk (.*);

// File: tb/txq_pair_sched_test.sv
module txq_pair_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hi_nonempty = 1'b0;
  logic       lo_nonempty = 1'b0;
  logic       pkt_done = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic       grant_hi;
  logic       grant_lo;

  int    tests = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  // reference model state
  bit m_hi = 1'b0;
  bit m_lo = 1'b0;
  int m_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_pair_sched uut (
    .clk(clk), .rst_n(rst_n), .hi_nonempty(hi_nonempty), .lo_nonempty(lo_nonempty),
    .pkt_done(pkt_done), .ratio_sel(ratio_sel), .grant_hi(grant_hi), .grant_lo(grant_lo)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 1'b0; m_lo = 1'b0; m_run = 0;
    end else if ((!m_hi && !m_lo) || pkt_done) begin
      m_hi = 1'b0; m_lo = 1'b0;
      if (hi_nonempty && lo_nonempty) begin
        if (ratio_sel == 0) m_hi = 1'b1;
        else if (m_run >= 8 - int'(ratio_sel)) begin m_lo = 1'b1; m_run = 0; end
        else begin m_hi = 1'b1; m_run = m_run + 1; end
      end else if (hi_nonempty) m_hi = 1'b1;
      else if (lo_nonempty) m_lo = 1'b1;
    end
  end

  task automatic compare();
    tests++;
    if (grant_hi !== m_hi || grant_lo !== m_lo) begin
      fails++;
      $display("FAIL %s: grant_hi/lo actual %b%b expected %b%b at %0t",
               tag, grant_hi, grant_lo, m_hi, m_lo, $time);
    end
  endtask

  // hmode/lmode: 0 empty, 1 always pending, 2 random
  task automatic run(int n, int hmode, int lmode, bit stray_done);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      hi_nonempty = (hmode == 1) || (hmode == 2 && ($urandom % 2 == 0));
      lo_nonempty = (lmode == 1) || (lmode == 2 && ($urandom % 2 == 0));
      if (grant_hi || grant_lo || stray_done) pkt_done = ($urandom % 3 == 0);
      else pkt_done = 1'b0;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    hi_nonempty = 1'b1; lo_nonempty = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;
    // R6: strict priority, bulk always waiting
    tag = "R6"; ratio_sel = 3'd0;
    run(300, 1, 1, 1'b0);
    run(300, 2, 1, 1'b0);
    // R7: intermediate ratios under full contention
    tag = "R7";
    for (int r = 1; r <= 6; r++) begin
      ratio_sel = 3'(r);
      run(400, 1, 1, 1'b0);
    end
    // R8: alternating share
    tag = "R8"; ratio_sel = 3'd7;
    run(400, 1, 1, 1'b0);
    // R5: one queue only, then contention resumes
    tag = "R5"; ratio_sel = 3'd5;
    run(200, 1, 0, 1'b0);
    run(200, 0, 1, 1'b0);
    run(200, 1, 1, 1'b0);
    // R4: both queues empty
    tag = "R4";
    run(100, 0, 0, 1'b0);
    // R9: stray done pulses while idle
    tag = "R9";
    run(600, 2, 2, 1'b1);
    // R2, R3: random mixed traffic over all settings
    tag = "R3";
    for (int r = 0; r < 8; r++) begin
      ratio_sel = 3'(r);
      run(500, 2, 2, 1'b0);
    end
    tag = "R2";
    run(1000, 2, 1, 1'b0);
    // R7: reset clears the run count
    tag = "R7"; ratio_sel = 3'd4;
    run(50, 1, 1, 1'b0);
    rst_n = 1'b0;
    run(3, 1, 1, 1'b0);
    rst_n = 1'b1;
    run(200, 1, 1, 1'b0);
    summary();
  end
endmodule